// File: doc/BRIEF.md
# Two-Phase Peak Current Trip PWM Controller

This block generates two fixed-frequency gate signals for an interleaved power stage that runs under cycle-by-cycle peak current control. A single period counter sets the switching frequency. The second phase runs half a period behind the first. At the start of its own period, each phase turns its gate on and begins to lower a digital threshold. The threshold starts at the current reference and drops by a programmable slope on every clock. It is sent to an external 12-bit converter, whose output feeds an analog comparator against the sensed phase current.

When the comparator reports that the current has reached the threshold, the phase switches its gate off for the rest of that period. The threshold then snaps back to the plain reference and holds there until the next period. Comparator events in the first few clocks after turn-on are ignored, so that switching spikes cannot end the pulse early. A maximum on-time also forces the gate off if no trip arrives.

The reference and slope inputs are captured into per-phase shadow registers only at that phase's period start. An outer loop can therefore change them at any time without corrupting a pulse that is already running.

Top module: `peak_trip_pwm`

## Requirements
- R1: Each phase turns its gate on in the clock cycle after its local period position is 0, and the gate stays on until a turn-off event.
- R2: During the k-th on-cycle of a phase (k = 1 is the first cycle the gate is high), the threshold output equals the shadowed reference minus (k-1) times the shadowed slope.
- R3: A trip seen at a clock edge after the blanking window turns the gate off in the next cycle, and the gate then stays off until that phase's next period start.
- R4: While a phase's gate is off, its threshold output equals that phase's shadowed reference.
- R5: Both phases use one common reference input. The period start of phase B comes exactly PERIOD/2 clock cycles after the period start of phase A.
- R6: A trip is ignored at any edge where the local period position is 1 to BLANK_CYC inclusive.
- R7: The threshold is a 12-bit unsigned value that holds at 0 and does not wrap when the ramp exceeds the reference.
- R8: If no trip has ended the pulse, the gate turns off at the edge where the local position is MAX_ON, so the on-time never exceeds MAX_ON cycles.
- R9: Changes to the reference or slope inputs take effect only at the affected phase's next period start.
- R10: While reset is asserted, both gates are low and both threshold outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iref_in | input | 12 | Common peak current reference |
| slope_in | input | SLOPE_W | Ramp decrement per clock |
| trip_a | input | 1 | Comparator trip for phase A |
| trip_b | input | 1 | Comparator trip for phase B |
| gate_a | output | 1 | Low-side gate drive, phase A |
| gate_b | output | 1 | Low-side gate drive, phase B |
| thr_a | output | 12 | Threshold code to the phase A DAC |
| thr_b | output | 12 | Threshold code to the phase B DAC |

## Verification
The assertions check on every cycle the following properties:
- the gate rises after each period start;
- the gate stays off once it is off within a period;
- a trip inside the blanking window does not end the pulse;
- the max-on cut-off fires;
- the threshold never rises during an on-time;
- the threshold equals the shadowed reference while the gate is off;
- the two period starts never coincide.

Several properties need the bench's scenarios. These are the exact ramp values for each slope, saturation against a small reference, the half-period offset between the phases, and the mid-period reference changes that must not reach a pulse already in progress. The bench checks all of these with a behavioural model driven by an emulated comparator with a rising current.

// File: rtl/pkt_pkg.sv
package pkt_pkg;
  localparam int DAC_W = 12;
  typedef logic [DAC_W-1:0] dac_t;

  // threshold = reference minus ramp, held at zero instead of wrapping
  function automatic dac_t thr_calc(input dac_t ref_v, input logic [31:0] ramp_v);
    logic [31:0] r32;
    r32 = 32'(ref_v);
    if (ramp_v >= r32) return '0;
    return dac_t'(r32 - ramp_v);
  endfunction
endpackage

// File: rtl/pkt_period_ctr.sv
module pkt_period_ctr #(
  parameter int PERIOD = 40,
  parameter int CNT_W  = $clog2(PERIOD)
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                  cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/pkt_phase_cell.sv
module pkt_phase_cell
  import pkt_pkg::*;
#(
  parameter int PERIOD    = 40,
  parameter int CNT_W     = $clog2(PERIOD),
  parameter int OFFSET    = 0,
  parameter int BLANK_CYC = 6,
  parameter int MAX_ON    = 36,
  parameter int SLOPE_W   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CNT_W-1:0]   cnt,
  input  dac_t               iref,
  input  logic [SLOPE_W-1:0] slope,
  input  logic               trip,
  output logic               gate_o,
  output dac_t               dac_o,
  output logic               start_ev
);
  localparam int RAMP_W = SLOPE_W + CNT_W + 1;
  localparam logic [CNT_W:0]   OFF_L = (CNT_W+1)'(OFFSET);
  localparam logic [CNT_W:0]   PER_L = (CNT_W+1)'(PERIOD);
  localparam logic [CNT_W-1:0] BLK_L = CNT_W'(BLANK_CYC);
  localparam logic [CNT_W-1:0] MAX_L = CNT_W'(MAX_ON);

  logic [CNT_W:0]     sum;
  logic [CNT_W-1:0]   lc;
  logic               trip_ev, max_ev, off_ev;
  logic               gate_q;
  logic [RAMP_W-1:0]  ramp_q;
  dac_t               ref_q;
  logic [SLOPE_W-1:0] slope_q;

  // local period position with this phase's offset
  assign sum      = {1'b0, cnt} + OFF_L;
  assign lc       = (sum >= PER_L) ? CNT_W'(sum - PER_L) : CNT_W'(sum);
  assign start_ev = (lc == '0);
  assign trip_ev  = gate_q && trip && (lc > BLK_L);
  assign max_ev   = gate_q && (lc == MAX_L);
  assign off_ev   = trip_ev || max_ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q  <= 1'b0;
      ramp_q  <= '0;
      ref_q   <= '0;
      slope_q <= '0;
    end else if (start_ev) begin
      gate_q  <= 1'b1;
      ramp_q  <= '0;
      ref_q   <= iref;
      slope_q <= slope;
    end else if (off_ev) begin
      gate_q  <= 1'b0;
      ramp_q  <= '0;
    end else if (gate_q) begin
      ramp_q  <= ramp_q + RAMP_W'(slope_q);
    end
  end

  assign gate_o = gate_q;
  assign dac_o  = thr_calc(ref_q, 32'(ramp_q));

  AST_GATE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> gate_q); // R1
  AST_THR_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
    gate_q && !start_ev |=> !gate_q || (dac_o <= $past(dac_o))); // R2
  AST_OFF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_q && !start_ev |=> !gate_q); // R3
  AST_OFF_AT_REF: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_q |-> dac_o == ref_q); // R4
  AST_BLANK_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    gate_q && trip && !start_ev && (lc <= BLK_L) |=> gate_q); // R6
  AST_THR_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    dac_o <= ref_q); // R7
  AST_MAX_ON_CUT: assert property (@(posedge clk) disable iff (!rst_n)
    (lc == MAX_L) |=> !gate_q); // R8
endmodule

// File: rtl/peak_trip_pwm.sv
module peak_trip_pwm
  import pkt_pkg::*;
#(
  parameter int PERIOD    = 40,
  parameter int BLANK_CYC = 6,
  parameter int MAX_ON    = 36,
  parameter int SLOPE_W   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [11:0]        iref_in,
  input  logic [SLOPE_W-1:0] slope_in,
  input  logic               trip_a,
  input  logic               trip_b,
  output logic               gate_a,
  output logic               gate_b,
  output logic [11:0]        thr_a,
  output logic [11:0]        thr_b
);
  localparam int CNT_W  = $clog2(PERIOD);
  localparam int NPHASE = 2;

  logic [CNT_W-1:0]  cnt;
  logic [NPHASE-1:0] trip_v, gate_v, start_v;
  dac_t              dac_v [NPHASE];

  assign trip_v = {trip_b, trip_a};

  pkt_period_ctr #(.PERIOD(PERIOD), .CNT_W(CNT_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .cnt(cnt)
  );

  for (genvar p = 0; p < NPHASE; p++) begin : g_ph
    pkt_phase_cell #(
      .PERIOD(PERIOD), .CNT_W(CNT_W), .OFFSET((PERIOD - p * (PERIOD / 2)) % PERIOD),
      .BLANK_CYC(BLANK_CYC), .MAX_ON(MAX_ON), .SLOPE_W(SLOPE_W)
    ) u_cell (
      .clk(clk), .rst_n(rst_n), .cnt(cnt), .iref(iref_in), .slope(slope_in),
      .trip(trip_v[p]), .gate_o(gate_v[p]), .dac_o(dac_v[p]), .start_ev(start_v[p])
    );
  end

  assign gate_a = gate_v[0];
  assign gate_b = gate_v[1];
  assign thr_a  = dac_v[0];
  assign thr_b  = dac_v[1];

  AST_STARTS_APART: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(start_v)); // R5
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> !gate_a && !gate_b && thr_a == '0 && thr_b == '0); // R10
endmodule

// File: tb/peak_trip_pwm_tb.sv
module peak_trip_pwm_tb_top;
  localparam int P  = 40;
  localparam int BL = 6;
  localparam int MX = 36;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [11:0] iref_in = '0;
  logic [7:0] slope_in = '0;
  logic       trip_a = 1'b0, trip_b = 1'b0;
  logic       gate_a, gate_b;
  logic [11:0] thr_a, thr_b;

  always #2 clk = ~clk;

  peak_trip_pwm #(.PERIOD(P), .BLANK_CYC(BL), .MAX_ON(MX), .SLOPE_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .iref_in(iref_in), .slope_in(slope_in),
    .trip_a(trip_a), .trip_b(trip_b), .gate_a(gate_a), .gate_b(gate_b),
    .thr_a(thr_a), .thr_b(thr_b)
  );

  int nchk = 0, nerr = 0;
  int tcnt = 0;
  int m_on[2], m_ramp[2], m_ref[2], m_slp[2];
  string gtag[2];
  int cur[2];
  int cur0 = 0, cstep = 0;
  bit force_trip = 0;
  int cyc = 0, rise_a = -1, rise_b = -1;
  bit pga = 0, pgb = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic int m_thr(input int p);
    return (m_ramp[p] >= m_ref[p]) ? 0 : m_ref[p] - m_ramp[p];
  endfunction

  // behavioural reference model, one step per rising edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tcnt = 0;
      for (int p = 0; p < 2; p++) begin
        m_on[p] = 0; m_ramp[p] = 0; m_ref[p] = 0; m_slp[p] = 0; gtag[p] = "R10";
      end
    end else begin
      for (int p = 0; p < 2; p++) begin
        int pos;
        bit tr;
        pos = (tcnt + P - p * (P / 2)) % P;
        tr  = (p == 0) ? trip_a : trip_b;
        if (pos == 0) begin
          m_on[p] = 1; m_ramp[p] = 0; m_ref[p] = iref_in; m_slp[p] = slope_in; gtag[p] = "R1";
        end else if (m_on[p] != 0) begin
          if (pos == MX) begin
            m_on[p] = 0; m_ramp[p] = 0; gtag[p] = "R8";
          end else if (tr && pos > BL) begin
            m_on[p] = 0; m_ramp[p] = 0; gtag[p] = "R3";
          end else begin
            m_ramp[p] += m_slp[p];
            gtag[p] = (tr) ? "R6" : "R2";
          end
        end
      end
      tcnt = (tcnt + 1) % P;
    end
  end

  task automatic compare_all();
    int ga, gb, ta, tb;
    ga = gate_a; gb = gate_b; ta = thr_a; tb = thr_b;
    chk(ga == m_on[0], gtag[0], ga, m_on[0]);
    chk(gb == m_on[1], gtag[1], gb, m_on[1]);
    for (int p = 0; p < 2; p++) begin
      string t;
      int act;
      act = (p == 0) ? ta : tb;
      if (m_on[p] == 0) t = "R4";
      else if (m_ramp[p] >= m_ref[p]) t = "R7";
      else if (int'(iref_in) != m_ref[p]) t = "R9";
      else t = "R2";
      chk(act == m_thr(p), t, act, m_thr(p));
    end
  endtask

  task automatic run(input int n, input bit wiggle);
    repeat (n) begin
      @(negedge clk);
      cyc++;
      compare_all();
      if (gate_a && !pga) rise_a = cyc;
      if (gate_b && !pgb && rise_a >= 0 && rise_b < 0) begin
        rise_b = cyc;
        chk(rise_b - rise_a == P / 2, "R5", rise_b - rise_a, P / 2);
      end
      pga = gate_a; pgb = gate_b;
      cur[0] = gate_a ? cur[0] + cstep : cur0;
      cur[1] = gate_b ? cur[1] + cstep : cur0;
      trip_a = force_trip || (gate_a && cur[0] >= int'(thr_a));
      trip_b = force_trip || (gate_b && cur[1] >= int'(thr_b));
      if (wiggle && (cyc % 7 == 3)) iref_in = iref_in ^ 12'h155;
    end
  endtask

  initial begin
    cur[0] = 0; cur[1] = 0;
    repeat (3) @(negedge clk);
    chk(gate_a == 0 && gate_b == 0, "R10", int'(gate_a) + int'(gate_b), 0);
    chk(thr_a == 0 && thr_b == 0, "R10", int'(thr_a) + int'(thr_b), 0);
    iref_in = 12'd2000; slope_in = 8'd20; cur0 = 1000; cstep = 40;
    @(negedge clk); rst_n = 1'b1;
    run(6 * P, 0);                                  // normal trips R3
    iref_in = 12'd3000; slope_in = 8'd5; cur0 = 0; cstep = 10;
    run(4 * P, 0);                                  // max on-time R8
    force_trip = 1; iref_in = 12'd1500; slope_in = 8'd10;
    run(4 * P, 0);                                  // blanking R6
    force_trip = 0; iref_in = 12'd500; slope_in = 8'd255; cur0 = 0; cstep = 0;
    run(4 * P, 0);                                  // saturation R7
    iref_in = 12'd2500; slope_in = 8'd30; cur0 = 500; cstep = 60;
    run(8 * P, 1);                                  // shadowing R9
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    #200000;
    nchk++; nerr++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule